// File: doc/BRIEF.md
# Three-Sample Streaming Median Filter

This block smooths a stream of unsigned words by replacing each incoming word with the middle value of that word and the two words that came before it. Words enter through a passive channel and leave through an active channel. Each channel uses a four-phase request/acknowledge handshake with a parallel data bus. Every accepted word produces exactly one result. The block does not start another input transfer until the result of the previous one has been delivered and its handshake has returned to zero.

Inside, the three most recent words sit in a small window. Each new word ages the window by one place. The ordering of the window is tracked with three less-or-equal flags. Two of these flags are compared afresh for every word. The third is inherited from the previous step, because the pair it describes was already compared one step earlier. The middle value is chosen by looking at which two of the three flags agree. After reset the window holds zeros, so the first two results are medians that include those zeros.

Top module: `median3_stream`

## Requirements
- R1: While reset is held, and after it is released, `in_ack` and `out_req` are 0 and `out_data` is 0.
- R2: `in_ack` rises only after `in_req` has been seen high. It stays high for as long as `in_req` stays high. It returns to 0 after `in_req` drops.
- R3: `in_ack` and `out_req` are never high in the same cycle. A request that arrives while a result is pending is acknowledged only after the output handshake has fully returned to zero.
- R4: `out_data` does not change while `out_req` is high.
- R5: Once raised, `out_req` stays high until `out_ack` is seen high. It then falls, and it is raised again only after `out_ack` has gone low.
- R6: Each result equals the median of the newest accepted word and the two words accepted before it. Positions that have not yet been filled since reset count as zero.
- R7: Exactly one result is produced for each accepted word, in the order the words were accepted.
- R8: Comparisons are unsigned, so a word with its top bit set (for example 8'h80) ranks above 8'h7F.
- R9: When two or three words in the window are equal, the result is that shared value whenever it is the middle one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Input channel request from the producer |
| in_data | input | W | Input word, valid while `in_req` is high |
| in_ack | output | 1 | Input channel acknowledge |
| out_req | output | 1 | Output channel request to the consumer |
| out_data | output | W | Median result, stable while `out_req` is high |
| out_ack | input | 1 | Output channel acknowledge from the consumer |

## Verification
The bound checker watches the handshake rules on every cycle: the ordering of request and acknowledge on both channels, the mutual exclusion of input acknowledge and output request, data stability during an output request, and the one-to-one pairing of accepted words with raised results. Only the bench scenarios can show that the delivered values are true medians. This covers the zero-filled start, equal words, words with the top bit set, and a long pseudo-random stream with varying consumer delay. The bench also shows that a request which arrives early is held off until the output has drained.

// File: rtl/median3_pkg.sv
// Package median3_pkg
// Shared types for the three-sample median filter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package median3_pkg;

    // Controller phases, one per handshake step
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // waiting for an input request
        ST_CMP     = 3'd1,  // comparing and latching the result
        ST_IN_ACK  = 3'd2,  // input acknowledged, waiting for request to drop
        ST_OUT_REQ = 3'd3,  // result offered, waiting for acknowledge
        ST_OUT_RTZ = 3'd4   // request withdrawn, waiting for acknowledge to drop
    } m3_state_t;

endpackage

// File: rtl/m3_ctrl.sv
// Module m3_ctrl
// Sequences one filter step: accept a word, compare, finish the input
// handshake, then run the output handshake to completion.
// Assumes the producer holds in_req high until in_ack rises, and the
// consumer holds out_ack high until out_req falls (four-phase rules).
module m3_ctrl
    import median3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic out_ack,
    output logic in_ack,
    output logic out_req,
    output logic load_en,
    output logic cmp_en
);

    m3_state_t state_q;
    m3_state_t state_d;

    // Next-state selection for the handshake sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_req)   state_d = ST_CMP;
            ST_CMP:                   state_d = ST_IN_ACK;
            ST_IN_ACK:  if (!in_req)  state_d = ST_OUT_REQ;
            ST_OUT_REQ: if (out_ack)  state_d = ST_OUT_RTZ;
            ST_OUT_RTZ: if (!out_ack) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode strobes and handshake outputs from the current phase
    always_comb begin
        load_en = (state_q == ST_IDLE) && in_req;
        cmp_en  = (state_q == ST_CMP);
        in_ack  = (state_q == ST_IN_ACK);
        out_req = (state_q == ST_OUT_REQ);
    end

endmodule

// File: rtl/m3_window.sv
// Module m3_window
// Holds the three newest words (newest, middle, oldest) and the ordering
// flags. On load_en the window ages by one place, the new word enters,
// and the inherited flag takes the previous newest-vs-middle result.
// On cmp_en the newest-vs-middle flag is stored for reuse next step.
// Assumes load_en and cmp_en are never high together.
module m3_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         cmp_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] w_new,
    output logic [W-1:0] w_mid,
    output logic [W-1:0] w_old,
    output logic         le_new_mid,
    output logic         le_old_new,
    output logic         le_mid_old
);

    logic [W-1:0] new_q, mid_q, old_q;
    logic         keep_nm_q;   // stored newest<=middle from the last compare
    logic         inh_mo_q;    // inherited middle<=oldest

    // Shift the window and take the new word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0;
            mid_q <= '0;
            old_q <= '0;
        end else if (load_en) begin
            old_q <= mid_q;
            mid_q <= new_q;
            new_q <= din;
        end
    end

    // Keep ordering flags: hand the old newest<=middle flag down the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_nm_q <= 1'b1;
            inh_mo_q  <= 1'b1;
        end else if (load_en) begin
            inh_mo_q  <= keep_nm_q;
        end else if (cmp_en) begin
            keep_nm_q <= le_new_mid;
        end
    end

    // Fresh unsigned comparisons on the current window contents
    always_comb begin
        le_new_mid = (new_q <= mid_q);
        le_old_new = (old_q <= new_q);
        le_mid_old = inh_mo_q;
        w_new      = new_q;
        w_mid      = mid_q;
        w_old      = old_q;
    end

endmodule

// File: rtl/m3_select.sv
// Module m3_select
// Picks the middle word from three ordering flags by finding the pair
// that agrees. Purely combinational.
// Assumes the flags describe w_new<=w_mid, w_old<=w_new and w_mid<=w_old.
module m3_select #(
    parameter int W = 8
) (
    input  logic [W-1:0] w_new,
    input  logic [W-1:0] w_mid,
    input  logic [W-1:0] w_old,
    input  logic         le_new_mid,
    input  logic         le_old_new,
    input  logic         le_mid_old,
    output logic [W-1:0] med
);

    // Agreement of two flags marks the word they both touch as middle
    always_comb begin
        if (le_old_new == le_new_mid)      med = w_new;
        else if (le_new_mid == le_mid_old) med = w_mid;
        else                               med = w_old;
    end

endmodule

// File: rtl/median3_stream.sv
// Module median3_stream (top)
// Streaming median of three over four-phase channels: passive input,
// active output. One result per accepted word; the next word is taken
// only after the output handshake has returned to zero.
// Assumes both partners obey the four-phase protocol.
module median3_stream #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_req,
    input  logic [W-1:0] in_data,
    output logic         in_ack,
    output logic         out_req,
    output logic [W-1:0] out_data,
    input  logic         out_ack
);

    logic         load_en, cmp_en;
    logic [W-1:0] w_new, w_mid, w_old, med;
    logic         le_new_mid, le_old_new, le_mid_old;
    logic [W-1:0] res_q;

    m3_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .out_ack (out_ack),
        .in_ack  (in_ack),
        .out_req (out_req),
        .load_en (load_en),
        .cmp_en  (cmp_en)
    );

    m3_window #(.W(W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .cmp_en     (cmp_en),
        .din        (in_data),
        .w_new      (w_new),
        .w_mid      (w_mid),
        .w_old      (w_old),
        .le_new_mid (le_new_mid),
        .le_old_new (le_old_new),
        .le_mid_old (le_mid_old)
    );

    m3_select #(.W(W)) u_select (
        .w_new      (w_new),
        .w_mid      (w_mid),
        .w_old      (w_old),
        .le_new_mid (le_new_mid),
        .le_old_new (le_old_new),
        .le_mid_old (le_mid_old),
        .med        (med)
    );

    // Result register: written only in the compare phase, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (cmp_en) res_q <= med;
    end

    assign out_data = res_q;

endmodule

// File: rtl/m3_checker.sv
// Module m3_checker
// Protocol checks for median3_stream, attached with bind below.
// Assumes a well-behaved producer that holds in_req until acknowledged.
module m3_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_req,
    input logic         in_ack,
    input logic         out_req,
    input logic [W-1:0] out_data,
    input logic         out_ack
);

    logic pend_q;  // an accepted word still owes a result

    // Track words acknowledged but not yet offered
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend_q <= 1'b0;
        else if (in_ack && !$past(in_ack))   pend_q <= 1'b1;
        else if (out_req && !$past(out_req)) pend_q <= 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!in_ack && !out_req && out_data == '0));

    assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(in_req));

    assert_ack_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && in_req) |=> in_ack);

    assert_channels_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ack && out_req));

    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req)) |-> $stable(out_data));

    assert_req_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> out_req);

    assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_req) |-> $past(out_ack));

    assert_offer_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> pend_q);

    assert_accept_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> !pend_q);

endmodule

bind median3_stream m3_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/median3_stream_tb.sv
// Bench for median3_stream: behavioural producer, consumer and model.
module median3_stream_tb;

    localparam int W       = 8;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int n_in  = 0;
    int n_out = 0;
    int ack_wait = 0;
    bit done = 1'b0;
    int hist [3] = '{0, 0, 0};
    int    exp_q [$];
    string tag_q [$];

    median3_stream #(.W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_data  (in_data),
        .in_ack   (in_ack),
        .out_req  (out_req),
        .out_data (out_data),
        .out_ack  (out_ack)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int med3(input int a, input int b, input int c);
        int lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        return (c < lo) ? lo : ((c > hi) ? hi : c);
    endfunction

    // Producer: one four-phase input transfer, holding the request extra cycles
    task automatic send_word(input int d, input int hold, input string tag);
        @(negedge clk);
        chk(in_ack == 1'b0, "R2", int'(in_ack), 0);
        in_data = d[W-1:0];
        in_req  = 1'b1;
        do @(negedge clk); while (!in_ack);
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = d;
        exp_q.push_back(med3(hist[0], hist[1], hist[2]));
        tag_q.push_back(tag);
        n_in++;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(in_ack == 1'b1, "R2", int'(in_ack), 1);
        end
        in_req = 1'b0;
        do @(negedge clk); while (in_ack);
    endtask

    // Consumer: accept each result after ack_wait cycles and compare it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_req && !out_ack) begin
                for (int i = 0; i < ack_wait; i++) begin
                    @(negedge clk);
                    chk(out_req == 1'b1, "R5", int'(out_req), 1);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", n_out + 1, n_in);
                end else begin
                    chk(out_data == exp_q[0][W-1:0], tag_q[0], int'(out_data), exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                out_ack = 1'b1;
                do @(negedge clk); while (out_req);
                out_ack = 1'b0;
                n_out++;
            end
        end
    end

    // Per-clock monitor: channel exclusion and held output data
    logic         prev_req = 1'b0;
    logic [W-1:0] prev_data = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(!(in_ack && out_req), "R3", int'(in_ack), 0);
                if (out_req && prev_req)
                    chk(out_data == prev_data, "R4", int'(out_data), int'(prev_data));
            end
            prev_req  = out_req;
            prev_data = out_data;
        end
    end

    // Wait until every accepted word has been delivered
    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_req || out_ack) && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: idle outputs during and after reset
        chk(in_ack == 1'b0 && out_req == 1'b0, "R1", int'(in_ack) + int'(out_req), 0);
        chk(out_data == '0, "R1", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ack == 1'b0 && out_req == 1'b0 && out_data == '0, "R1", int'(out_data), 0);

        // R6: zero-filled start, then a full window
        send_word(5, 0, "R6");
        send_word(7, 2, "R6");
        send_word(3, 0, "R6");
        send_word(12, 1, "R6");
        drain();

        // R9: ties of two and three equal words
        ack_wait = 2;
        send_word(9, 0, "R9");
        send_word(9, 0, "R9");
        send_word(4, 0, "R9");
        send_word(6, 0, "R9");
        send_word(6, 0, "R9");
        send_word(6, 0, "R9");
        send_word(2, 0, "R9");
        drain();

        // R8: top-bit words rank above 8'h7F
        ack_wait = 1;
        send_word(8'h7F, 0, "R8");
        send_word(8'h80, 0, "R8");
        send_word(8'h01, 0, "R8");
        send_word(8'hFF, 0, "R8");
        send_word(8'h7F, 0, "R8");
        drain();

        // R3/R6: long stream, early requests, varied consumer delay
        for (int k = 0; k < 80; k++) begin
            ack_wait = k % 4;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send_word(int'(lfsr), k % 3, "R6");
        end
        drain();

        // R7: one result per accepted word
        chk(n_out == n_in, "R7", n_out, n_in);
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_out, n_in);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule